// File: doc/BRIEF.md
# Per-Line Activation Delay Selector

This block sits in a DRAM controller's command path, between the scheduler and the command bus. The scheduler hands it a column command: read or write, bank, row and logical cache-line index. One cycle later the block returns two things. The first is the physical column position the line should use. The second is the number of cycles the command must still wait before it can legally follow the row's activate. The activate-to-column delay is not fixed. It is chosen per cache line from a static profile that marks each column group of each subarray as weak or strong.

Reads whose physical column is made only of strong bitlines get a shortened delay. Reads that touch a weak group get the standard delay. Writes always get a much shorter delay, whatever the profile says. Inside each subarray the block also swaps logical line 0 with the lowest-numbered strong physical line. The line that is usually requested first therefore lands on strong bitlines.

The profile is loaded once through a small configuration port and then sealed by a commit strobe. A per-bank timer counts the cycles since each bank's last activate. The block subtracts that count from the chosen delay and floors the result at zero.

Top module: `lvl_trcd_select`

## Requirements
- R1: After reset, res_vld is 0, res_col and res_wait are 0, the profile is not valid, and every bank timer counts as long expired. A command to a bank that has had no activate returns a wait of 0.
- R2: Each command accepted with cmd_vld at a clock edge produces res_vld high for exactly the following cycle. While res_vld is low, res_col and res_wait are 0.
- R3: Before the profile is committed, a read uses the standard delay T_STD and res_col equals cmd_col.
- R4: With the profile committed, a read whose physical column group is marked strong (weak bit 0) uses the shortened delay T_RD_FAST.
- R5: With the profile committed, a read whose physical column group is marked weak (weak bit 1) uses T_STD.
- R6: A write uses the delay T_WR, whether or not the profile is valid and whatever the column's weak bit.
- R7: With the profile committed, let p be the lowest-numbered physical group that is strong in the row's subarray. Logical line 0 maps to p, logical line p maps to 0, and every other line maps to itself. If the subarray has no strong group, the mapping is the identity. The weak bit used by R4 and R5 is the one of the physical group. The subarray index is cmd_row[7:6].
- R8: Let N be the number of clock edges from the edge that samples a bank's act_vld to the edge that samples a command to that bank. The wait is max(delay − N, 0). An activate to another bank does not change this count.
- R9: cfg_we writes cfg_weak into the bit for (cfg_sub, cfg_grp) only while the profile is not yet valid. cfg_commit makes the profile valid. Writes after the commit are ignored, and the profile stays valid until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_we | input | 1 | Profile bit write strobe |
| cfg_sub | input | 2 | Subarray index of the profile write |
| cfg_grp | input | 3 | Physical column group of the profile write |
| cfg_weak | input | 1 | 1 marks the group weak |
| cfg_commit | input | 1 | Seals the profile and marks it valid |
| act_vld | input | 1 | Activate issued this cycle |
| act_bank | input | 2 | Bank of the activate |
| cmd_vld | input | 1 | Column command present |
| cmd_wr | input | 1 | 1 for write, 0 for read |
| cmd_bank | input | 2 | Bank of the command |
| cmd_row | input | 8 | Open row of the command |
| cmd_col | input | 3 | Logical cache-line index in the row |
| res_vld | output | 1 | Result valid |
| res_col | output | 3 | Physical cache-line position |
| res_wait | output | 5 | Cycles left before the command may issue |

## Verification
A corrupted profile bit shows up on the next read that touches that subarray. Depending on which bit is wrong, the read returns a wait too short or too long by T_STD − T_RD_FAST, or lands on the wrong column when the first strong group moves. A bank timer that is off shows as a wait off by the same amount on the next command to that bank. A timer that fails to saturate or that leaks between banks shows once a second bank's activate lands between two commands. Every error appears on res_col or res_wait in the cycle right after the command that exposes it. The scoreboard checks each result against a model built only from the requirements.

// File: rtl/lvl_pkg.sv
package lvl_pkg;

    localparam int LVL_BANKS  = 4;
    localparam int LVL_BANK_W = $clog2(LVL_BANKS);
    localparam int LVL_ROW_W  = 8;
    localparam int LVL_SUBS   = 4;
    localparam int LVL_SUB_W  = $clog2(LVL_SUBS);
    localparam int LVL_LINES  = 8;
    localparam int LVL_COL_W  = $clog2(LVL_LINES);
    localparam int LVL_WAIT_W = 5;

    typedef logic [LVL_BANK_W-1:0] bank_t;
    typedef logic [LVL_SUB_W-1:0]  sub_t;
    typedef logic [LVL_COL_W-1:0]  col_t;
    typedef logic [LVL_WAIT_W-1:0] wait_t;
    typedef logic [LVL_LINES-1:0]  weak_row_t;

    typedef enum logic [1:0] {
        DLY_STD  = 2'd0,
        DLY_FAST = 2'd1,
        DLY_WR   = 2'd2
    } dly_class_e;

    typedef struct packed {
        logic                 wr;
        bank_t                bank;
        logic [LVL_ROW_W-1:0] row;
        col_t                 col;
    } col_cmd_t;

    typedef struct packed {
        col_t  col;
        wait_t wait_c;
    } col_res_t;

    function automatic sub_t sub_of_row(input logic [LVL_ROW_W-1:0] row);
        return row[LVL_ROW_W-1 -: LVL_SUB_W];
    endfunction

    function automatic wait_t floor_sub(input wait_t dly, input wait_t spent);
        return (dly > spent) ? wait_t'(dly - spent) : '0;
    endfunction

endpackage

// File: rtl/lvl_profile_store.sv
module lvl_profile_store
    import lvl_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      wr_en,
    input  sub_t      wr_sub,
    input  col_t      wr_grp,
    input  logic      wr_weak,
    input  logic      seal,
    input  sub_t      rd_sub,
    output weak_row_t rd_weak,
    output logic      valid
);
    weak_row_t weak_q [LVL_SUBS];
    logic      valid_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            valid_q <= 1'b0;
            for (int s = 0; s < LVL_SUBS; s++) begin
                weak_q[s] <= '0;
            end
        end else begin
            if (wr_en && !valid_q) begin
                weak_q[wr_sub][wr_grp] <= wr_weak;
            end
            if (seal) begin
                valid_q <= 1'b1;
            end
        end
    end

    assign rd_weak = weak_q[rd_sub];
    assign valid   = valid_q;

endmodule

// File: rtl/lvl_line_remap.sv
module lvl_line_remap
    import lvl_pkg::*;
(
    input  logic      enable,
    input  weak_row_t weak_vec,
    input  col_t      lcol,
    output col_t      pcol
);
    logic found;
    col_t first;

    always_comb begin
        found = 1'b0;
        first = '0;
        for (int i = 0; i < LVL_LINES; i++) begin
            if (!found && !weak_vec[i]) begin
                found = 1'b1;
                first = col_t'(i);
            end
        end
    end

    always_comb begin
        pcol = lcol;
        if (enable && found) begin
            if (lcol == '0) begin
                pcol = first;
            end else if (lcol == first) begin
                pcol = '0;
            end
        end
    end

endmodule

// File: rtl/lvl_act_timer.sv
module lvl_act_timer
    import lvl_pkg::*;
#(
    parameter int SAT = 10
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  act_vld,
    input  bank_t act_bank,
    input  bank_t qry_bank,
    output wait_t elapsed
);
    wait_t cnt_q [LVL_BANKS];

    for (genvar b = 0; b < LVL_BANKS; b++) begin : g_bank
        always_ff @(posedge clk) begin
            if (rst) begin
                cnt_q[b] <= wait_t'(SAT);
            end else if (act_vld && act_bank == bank_t'(b)) begin
                cnt_q[b] <= wait_t'(1);
            end else if (cnt_q[b] < wait_t'(SAT)) begin
                cnt_q[b] <= cnt_q[b] + wait_t'(1);
            end
        end
    end

    assign elapsed = cnt_q[qry_bank];

endmodule

// File: rtl/lvl_trcd_select.sv
module lvl_trcd_select
    import lvl_pkg::*;
#(
    parameter int T_STD     = 10,
    parameter int T_RD_FAST = 6,
    parameter int T_WR      = 3
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 cfg_we,
    input  logic [LVL_SUB_W-1:0] cfg_sub,
    input  logic [LVL_COL_W-1:0] cfg_grp,
    input  logic                 cfg_weak,
    input  logic                 cfg_commit,
    input  logic                 act_vld,
    input  logic [LVL_BANK_W-1:0] act_bank,
    input  logic                 cmd_vld,
    input  logic                 cmd_wr,
    input  logic [LVL_BANK_W-1:0] cmd_bank,
    input  logic [LVL_ROW_W-1:0] cmd_row,
    input  logic [LVL_COL_W-1:0] cmd_col,
    output logic                 res_vld,
    output logic [LVL_COL_W-1:0] res_col,
    output logic [LVL_WAIT_W-1:0] res_wait
);
    col_cmd_t   cmd;
    sub_t       cmd_sub;
    weak_row_t  sub_weak;
    logic       prof_ok;
    col_t       phys_col;
    wait_t      since_act;
    dly_class_e dly_cls;
    wait_t      dly_val;
    col_res_t   res_d;
    col_res_t   res_q;
    logic       vld_q;

    assign cmd     = '{wr: cmd_wr, bank: cmd_bank, row: cmd_row, col: cmd_col};
    assign cmd_sub = sub_of_row(cmd.row);

    lvl_profile_store prof_i (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (cfg_we),
        .wr_sub  (cfg_sub),
        .wr_grp  (cfg_grp),
        .wr_weak (cfg_weak),
        .seal    (cfg_commit),
        .rd_sub  (cmd_sub),
        .rd_weak (sub_weak),
        .valid   (prof_ok)
    );

    lvl_line_remap remap_i (
        .enable   (prof_ok),
        .weak_vec (sub_weak),
        .lcol     (cmd.col),
        .pcol     (phys_col)
    );

    lvl_act_timer #(.SAT(T_STD)) timer_i (
        .clk      (clk),
        .rst      (rst),
        .act_vld  (act_vld),
        .act_bank (act_bank),
        .qry_bank (cmd.bank),
        .elapsed  (since_act)
    );

    always_comb begin
        if (cmd.wr) begin
            dly_cls = DLY_WR;
        end else if (prof_ok && !sub_weak[phys_col]) begin
            dly_cls = DLY_FAST;
        end else begin
            dly_cls = DLY_STD;
        end
    end

    always_comb begin
        unique case (dly_cls)
            DLY_WR:   dly_val = wait_t'(T_WR);
            DLY_FAST: dly_val = wait_t'(T_RD_FAST);
            default:  dly_val = wait_t'(T_STD);
        endcase
    end

    assign res_d = '{col: phys_col, wait_c: floor_sub(dly_val, since_act)};

    always_ff @(posedge clk) begin
        if (rst) begin
            vld_q <= 1'b0;
            res_q <= '0;
        end else begin
            vld_q <= cmd_vld;
            res_q <= cmd_vld ? res_d : '0;
        end
    end

    assign res_vld  = vld_q;
    assign res_col  = res_q.col;
    assign res_wait = res_q.wait_c;

endmodule

// File: rtl/lvl_trcd_chk.sv
module lvl_trcd_chk
    import lvl_pkg::*;
#(
    parameter int T_STD = 10,
    parameter int T_WR  = 3
) (
    input logic                  clk,
    input logic                  rst,
    input logic                  cmd_vld,
    input logic                  cmd_wr,
    input logic [LVL_COL_W-1:0]  cmd_col,
    input logic                  prof_ok,
    input logic                  res_vld,
    input logic [LVL_COL_W-1:0]  res_col,
    input logic [LVL_WAIT_W-1:0] res_wait
);
    // R2
    res_follows_cmd_chk: assert property (@(posedge clk) disable iff (rst)
        res_vld == $past(cmd_vld));

    // R2
    res_idle_zero_chk: assert property (@(posedge clk) disable iff (rst)
        !res_vld |-> (res_col == '0 && res_wait == '0));

    // R6
    wr_short_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && $past(cmd_wr)) |-> (res_wait <= LVL_WAIT_W'(T_WR)));

    // R3
    invalid_identity_chk: assert property (@(posedge clk) disable iff (rst)
        (res_vld && !$past(prof_ok)) |-> (res_col == $past(cmd_col)));

    // R8
    wait_bound_chk: assert property (@(posedge clk) disable iff (rst)
        res_vld |-> (res_wait <= LVL_WAIT_W'(T_STD)));

    // R9
    prof_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        $past(prof_ok) |-> prof_ok);

endmodule

bind lvl_trcd_select lvl_trcd_chk #(.T_STD(T_STD), .T_WR(T_WR)) chk_i (
    .clk      (clk),
    .rst      (rst),
    .cmd_vld  (cmd_vld),
    .cmd_wr   (cmd_wr),
    .cmd_col  (cmd_col),
    .prof_ok  (prof_ok),
    .res_vld  (res_vld),
    .res_col  (res_col),
    .res_wait (res_wait)
);

// File: tb/lvl_trcd_select_tb_top.sv
module lvl_trcd_select_tb_top;

    localparam int CLK_PERIOD = 10;
    localparam int TS  = 10;
    localparam int TF  = 6;
    localparam int TW  = 3;

    typedef struct {
        int    col;
        int    wt;
        string tag;
    } exp_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_we = 1'b0;
    logic [1:0] cfg_sub = '0;
    logic [2:0] cfg_grp = '0;
    logic       cfg_weak = 1'b0;
    logic       cfg_commit = 1'b0;
    logic       act_vld = 1'b0;
    logic [1:0] act_bank = '0;
    logic       cmd_vld = 1'b0;
    logic       cmd_wr = 1'b0;
    logic [1:0] cmd_bank = '0;
    logic [7:0] cmd_row = '0;
    logic [2:0] cmd_col = '0;
    logic       res_vld;
    logic [2:0] res_col;
    logic [4:0] res_wait;

    int   nvec = 0;
    int   nerr = 0;
    int   edge_cnt = 0;
    bit   done = 1'b0;
    bit   bweak [4][8];
    bit   bvalid = 1'b0;
    int   act_edge [4] = '{-1000, -1000, -1000, -1000};
    exp_t q[$];

    always #(CLK_PERIOD/2) clk = ~clk;
    always @(posedge clk) edge_cnt <= edge_cnt + 1;

    lvl_trcd_select #(.T_STD(TS), .T_RD_FAST(TF), .T_WR(TW)) dut_i (
        .clk(clk), .rst(rst),
        .cfg_we(cfg_we), .cfg_sub(cfg_sub), .cfg_grp(cfg_grp),
        .cfg_weak(cfg_weak), .cfg_commit(cfg_commit),
        .act_vld(act_vld), .act_bank(act_bank),
        .cmd_vld(cmd_vld), .cmd_wr(cmd_wr), .cmd_bank(cmd_bank),
        .cmd_row(cmd_row), .cmd_col(cmd_col),
        .res_vld(res_vld), .res_col(res_col), .res_wait(res_wait)
    );

    function automatic int model_phys(int s, int l);
        int p = -1;
        if (!bvalid) return l;
        for (int i = 0; i < 8; i++) begin
            if (p < 0 && !bweak[s][i]) p = i;
        end
        if (p < 0) return l;
        if (l == 0) return p;
        if (l == p) return 0;
        return l;
    endfunction

    task automatic cfg_write(int s, int g, bit w);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sub = 2'(s); cfg_grp = 3'(g); cfg_weak = w;
        if (!bvalid) bweak[s][g] = w;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic commit();
        @(negedge clk);
        cfg_commit = 1'b1;
        @(posedge clk); #1;
        cfg_commit = 1'b0;
        bvalid = 1'b1;
    endtask

    task automatic activate(int b);
        @(negedge clk);
        act_vld = 1'b1; act_bank = 2'(b);
        act_edge[b] = edge_cnt + 1;
        @(posedge clk); #1;
        act_vld = 1'b0;
    endtask

    task automatic issue(bit wr, int b, int row, int col, string tag);
        int s, pc, t, n;
        exp_t e;
        @(negedge clk);
        s  = row >> 6;
        pc = model_phys(s, col);
        t  = wr ? TW : ((!bvalid || bweak[s][pc]) ? TS : TF);
        n  = edge_cnt + 1 - act_edge[b];
        e.col = pc;
        e.wt  = (t > n) ? t - n : 0;
        e.tag = tag;
        q.push_back(e);
        cmd_vld = 1'b1; cmd_wr = wr; cmd_bank = 2'(b);
        cmd_row = 8'(row); cmd_col = 3'(col);
        @(posedge clk); #1;
        cmd_vld = 1'b0;
    endtask

    // Monitor: pop expected items as results appear.
    always @(negedge clk) begin
        if (!rst && !done && res_vld) begin
            exp_t e;
            nvec++;
            if (q.size() == 0) begin
                nerr++;
                $display("FAIL R2: result without command, actual vld=1 expected vld=0");
            end else begin
                e = q.pop_front();
                if (int'(res_col) != e.col || int'(res_wait) != e.wt) begin
                    nerr++;
                    $display("FAIL %s: actual col=%0d wait=%0d expected col=%0d wait=%0d",
                             e.tag, res_col, res_wait, e.col, e.wt);
                end
            end
        end
    end

    task automatic finish_run();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", nvec, nerr);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            nerr++;
            $display("FAIL watchdog: actual=hung expected=finished");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        nvec++;
        if (res_vld !== 1'b0 || res_col !== 3'd0 || res_wait !== 5'd0) begin
            nerr++;
            $display("FAIL R1: actual vld=%0b col=%0d wait=%0d expected 0 0 0",
                     res_vld, res_col, res_wait);
        end
        // R1: no activate yet on bank 3, timer expired
        issue(1'b0, 3, 8'h00, 5, "R1");
        // R3 profile not valid: standard delay, identity column; R8 N=1,2
        activate(0);
        issue(1'b0, 0, 8'h10, 0, "R3");
        issue(1'b0, 0, 8'h10, 3, "R3");
        // R6 write before commit
        issue(1'b1, 0, 8'h10, 1, "R6");

        // profile load (R9)
        cfg_write(0, 0, 1'b1);
        cfg_write(0, 1, 1'b1);
        for (int g = 0; g < 8; g++) cfg_write(2, g, 1'b1);
        cfg_write(3, 3, 1'b1);
        cfg_write(3, 5, 1'b1);
        commit();
        cfg_write(1, 0, 1'b1); // R9: ignored after commit

        // subarray 0: first strong group is 2
        activate(1);
        issue(1'b0, 1, 8'h05, 0, "R7");
        issue(1'b0, 1, 8'h05, 2, "R7");
        issue(1'b0, 1, 8'h05, 1, "R5");
        issue(1'b0, 1, 8'h05, 4, "R4");
        // subarray 1: write after commit ignored, group 0 still strong
        activate(2);
        issue(1'b0, 2, 8'h45, 0, "R9");
        // subarray 2: all weak, identity map, standard
        activate(0);
        issue(1'b0, 0, 8'h85, 0, "R7");
        // subarray 3
        activate(1);
        issue(1'b0, 1, 8'hC0, 3, "R5");
        issue(1'b0, 1, 8'hC0, 0, "R4");
        issue(1'b1, 1, 8'hC0, 3, "R6");
        activate(2);
        issue(1'b1, 2, 8'h45, 1, "R6");
        activate(0);
        issue(1'b1, 0, 8'h10, 1, "R6");

        // R8: other-bank activate does not disturb, wait floors at zero
        activate(3);
        repeat (2) @(posedge clk);
        activate(2);
        issue(1'b0, 3, 8'h00, 4, "R8");
        issue(1'b0, 3, 8'h00, 4, "R8");
        issue(1'b0, 3, 8'h00, 4, "R8");
        issue(1'b0, 3, 8'h00, 4, "R8");

        repeat (3) @(posedge clk);
        @(negedge clk);
        // R2: every command answered, outputs idle at zero
        nvec++;
        if (q.size() != 0 || res_vld !== 1'b0 || res_col !== 3'd0 || res_wait !== 5'd0) begin
            nerr++;
            $display("FAIL R2: actual pending=%0d vld=%0b col=%0d wait=%0d expected 0 0 0 0",
                     q.size(), res_vld, res_col, res_wait);
        end
        finish_run();
    end

endmodule